// File: doc/BRIEF.md
# Programmable Event Counter and Interval Timer

This block is an 8-bit down counter that can be clocked from several sources: a strobe divided by a 32-step prescaler (interval timing), the rising edges of either of two external flag lines (event counting), or the strobe gated by a flag line being high (pulse-width measurement). A holding register supplies the reload value. When the count steps from one to zero, the counter reloads instead, sets a terminal-count flag and, if enabled, asks the surrounding logic to invert its single-bit output latch.

Control comes from single-cycle commands. Each command is a 4-bit code with a valid strobe and an 8-bit data operand. Start commands select a clock source. A stop command halts counting and clears the prescaler. Other commands load the reload value, read the count, step the counter by hand, arm the output toggle, and mask or unmask the interrupt. Both flag lines are treated as asynchronous and pass through a synchronizer before any edge is detected.

Top module: `evt_timer`

## Requirements
- R1: A load command (code 1) while the block is stopped writes `d_in` into both the count and the reload value and clears `tc_flag`, all visible after the next clock edge.
- R2: A load command (code 1) while any counting mode is active writes only the reload value; the count keeps its value, and the new value is used at the next terminal reload.
- R3: A stop command (code 3) returns the block to the stopped state and clears the prescaler to zero, so a later timer start needs a full 32 strobes before its first step; strobes and flag edges do not step a stopped counter.
- R4: A count step at value 1 loads the reload value and sets `tc_flag`; a step at any other value subtracts one, and value 0 wraps to 255 without touching `tc_flag`.
- R5: In timer mode (code 5), every 32nd strobe cycle on `tstrobe` steps the counter once.
- R6: In event mode A (code 6) or B (code 7), each rising edge of `flag_a` or `flag_b` respectively steps the counter; the other line is ignored. Each flag passes through two synchronizer flops, and the step is applied at the third rising clock edge, counting the first edge that samples the new high level.
- R7: In gated mode A (code 8) or B (code 9), each strobe cycle steps the counter while the synchronized selected flag is high; the synchronized falling edge of that flag puts the block in the stopped state.
- R8: After the toggle-arm command (code 10), every step at value 1 raises `out_toggle` for exactly one cycle, in the same cycle as the reload; before arming, no step does.
- R9: A read command (code 2) presents the count in `get_data`, with `get_valid` high for one cycle after the next edge.
- R10: `irq` is high exactly when `tc_flag` is set and the interrupt is unmasked; code 11 unmasks it, code 12 masks it, and reset leaves it masked with count, reload value and `tc_flag` at zero.
- R11: A step command (code 4) steps the counter as in R4. In a cycle that carries a load, stop or step command, any step from the active mode is dropped.
- R12: Codes 0, 13, 14 and 15 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tstrobe | input | 1 | Machine-cycle timing strobe, one clock wide, synchronous to clk |
| flag_a | input | 1 | External flag line A, asynchronous |
| flag_b | input | 1 | External flag line B, asynchronous |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 4 | Command code |
| d_in | input | 8 | Command data operand |
| count | output | 8 | Current counter value |
| get_valid | output | 1 | Read result valid |
| get_data | output | 8 | Counter value captured by a read command |
| tc_flag | output | 1 | Terminal-count flag |
| irq | output | 1 | Interrupt request |
| out_toggle | output | 1 | One-cycle request to invert the output latch |

## Verification
The bench builds the block with its default parameters: an 8-bit counter, a prescaler of 32 and two synchronizer stages. These values put the 0-to-255 wrap, a full prescaler period after a stop, and the exact three-edge flag latency in reach within a few hundred cycles. A behavioural model, driven by the same stimulus, follows every mode switch, gated-mode end and command collision. It is compared with all outputs on every cycle.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;

  localparam logic [3:0] CMD_LOAD    = 4'h1;
  localparam logic [3:0] CMD_GET     = 4'h2;
  localparam logic [3:0] CMD_STOP    = 4'h3;
  localparam logic [3:0] CMD_STEP    = 4'h4;
  localparam logic [3:0] CMD_TIMER   = 4'h5;
  localparam logic [3:0] CMD_EVT_A   = 4'h6;
  localparam logic [3:0] CMD_EVT_B   = 4'h7;
  localparam logic [3:0] CMD_GATE_A  = 4'h8;
  localparam logic [3:0] CMD_GATE_B  = 4'h9;
  localparam logic [3:0] CMD_TOG_ARM = 4'hA;
  localparam logic [3:0] CMD_IRQ_ON  = 4'hB;
  localparam logic [3:0] CMD_IRQ_OFF = 4'hC;

  typedef enum logic [2:0] {
    MD_IDLE,
    MD_TIMER,
    MD_EVT_A,
    MD_EVT_B,
    MD_GATE_A,
    MD_GATE_B
  } mode_e;

  function automatic logic is_start(input logic [3:0] code);
    return (code >= CMD_TIMER) && (code <= CMD_GATE_B);
  endfunction

  function automatic mode_e start_mode(input logic [3:0] code);
    mode_e m;
    case (code)
      CMD_TIMER:  m = MD_TIMER;
      CMD_EVT_A:  m = MD_EVT_A;
      CMD_EVT_B:  m = MD_EVT_B;
      CMD_GATE_A: m = MD_GATE_A;
      CMD_GATE_B: m = MD_GATE_B;
      default:    m = MD_IDLE;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/evt_timer_sync.sv
module evt_timer_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic level,
  output logic rise,
  output logic fall
);
  localparam int LAST = STAGES;

  logic [LAST:0] chain_q;

  always_ff @(posedge clk) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[LAST-1:0], async_in};
  end

  assign level = chain_q[LAST-1];
  assign rise  = chain_q[LAST-1] & ~chain_q[LAST];
  assign fall  = ~chain_q[LAST-1] & chain_q[LAST];

endmodule

// File: rtl/evt_timer_prescaler.sv
module evt_timer_prescaler #(
  parameter int DIV = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic adv,
  output logic wrap
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] TOP = CW'(DIV - 1);

  logic [CW-1:0] phase_q;

  function automatic logic [CW-1:0] next_phase(input logic [CW-1:0] cur);
    return (cur == TOP) ? '0 : cur + CW'(1);
  endfunction

  assign wrap = adv && (phase_q == TOP);

  always_ff @(posedge clk) begin
    if (!rst_n)   phase_q <= '0;
    else if (clr) phase_q <= '0;
    else if (adv) phase_q <= next_phase(phase_q);
  end

  assert_prescale_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (phase_q == '0));

  assert_prescale_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q <= TOP);

endmodule

// File: rtl/evt_timer_core.sv
module evt_timer_core
  import evt_timer_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tstrobe,
  input  logic [1:0]       flag_lvl,
  input  logic [1:0]       flag_rise,
  input  logic [1:0]       flag_fall,
  input  logic             presc_wrap,
  output logic             presc_adv,
  output logic             presc_clr,
  input  logic             cmd_valid,
  input  logic [3:0]       cmd_code,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] count,
  output logic             get_valid,
  output logic [WIDTH-1:0] get_data,
  output logic             tc_flag,
  output logic             irq,
  output logic             out_toggle
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  function automatic logic [WIDTH-1:0] stepped(input logic [WIDTH-1:0] cur,
                                               input logic [WIDTH-1:0] reload);
    return (cur == ONE) ? reload : cur - ONE;
  endfunction

  mode_e            mode_q, mode_d;
  logic [WIDTH-1:0] cnt_q, hold_q;
  logic             tc_q, irq_en_q, tog_arm_q, tog_q, gv_q;
  logic [WIDTH-1:0] gd_q;

  logic load_cmd, stop_cmd, step_cmd, get_cmd;
  logic running, load_stopped, load_running, tick_blocked;
  logic mode_tick, step_now, terminal, gate_end;

  assign load_cmd  = cmd_valid && (cmd_code == CMD_LOAD);
  assign stop_cmd  = cmd_valid && (cmd_code == CMD_STOP);
  assign step_cmd  = cmd_valid && (cmd_code == CMD_STEP);
  assign get_cmd   = cmd_valid && (cmd_code == CMD_GET);

  assign running      = (mode_q != MD_IDLE);
  assign load_stopped = load_cmd && !running;
  assign load_running = load_cmd && running;
  assign tick_blocked = load_cmd || stop_cmd || step_cmd;

  always_comb begin
    case (mode_q)
      MD_TIMER:  mode_tick = presc_wrap;
      MD_EVT_A:  mode_tick = flag_rise[0];
      MD_EVT_B:  mode_tick = flag_rise[1];
      MD_GATE_A: mode_tick = tstrobe && flag_lvl[0];
      MD_GATE_B: mode_tick = tstrobe && flag_lvl[1];
      default:   mode_tick = 1'b0;
    endcase
  end

  assign presc_adv = tstrobe && (mode_q == MD_TIMER);
  assign presc_clr = stop_cmd;

  assign step_now = step_cmd || (mode_tick && !tick_blocked);
  assign terminal = step_now && (cnt_q == ONE);
  assign gate_end = ((mode_q == MD_GATE_A) && flag_fall[0]) ||
                    ((mode_q == MD_GATE_B) && flag_fall[1]);

  always_comb begin
    mode_d = mode_q;
    if (cmd_valid && is_start(cmd_code)) mode_d = start_mode(cmd_code);
    else if (stop_cmd)                   mode_d = MD_IDLE;
    else if (gate_end)                   mode_d = MD_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q    <= MD_IDLE;
      cnt_q     <= '0;
      hold_q    <= '0;
      tc_q      <= 1'b0;
      irq_en_q  <= 1'b0;
      tog_arm_q <= 1'b0;
      tog_q     <= 1'b0;
      gv_q      <= 1'b0;
      gd_q      <= '0;
    end else begin
      mode_q <= mode_d;
      tog_q  <= terminal && tog_arm_q;
      gv_q   <= get_cmd;
      if (get_cmd) gd_q <= cnt_q;
      if (load_cmd) hold_q <= d_in;
      if (load_stopped)  cnt_q <= d_in;
      else if (step_now) cnt_q <= stepped(cnt_q, hold_q);
      if (load_stopped)  tc_q <= 1'b0;
      else if (terminal) tc_q <= 1'b1;
      if (cmd_valid && cmd_code == CMD_TOG_ARM) tog_arm_q <= 1'b1;
      if (cmd_valid && cmd_code == CMD_IRQ_ON)  irq_en_q  <= 1'b1;
      else if (cmd_valid && cmd_code == CMD_IRQ_OFF) irq_en_q <= 1'b0;
    end
  end

  assign count      = cnt_q;
  assign tc_flag    = tc_q;
  assign irq        = tc_q && irq_en_q;
  assign out_toggle = tog_q;
  assign get_valid  = gv_q;
  assign get_data   = gd_q;

  assert_load_stopped_R1: assert property (@(posedge clk) disable iff (!rst_n)
    load_stopped |=> (cnt_q == $past(d_in)) && !tc_q);

  assert_load_running_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load_running |=> (hold_q == $past(d_in)) && (cnt_q == $past(cnt_q)));

  assert_stop_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    stop_cmd |=> (mode_q == MD_IDLE));

  assert_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
    terminal |=> (cnt_q == $past(hold_q)) && tc_q);

  assert_gate_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_end && !cmd_valid) |=> (mode_q == MD_IDLE));

  assert_toggle_armed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tog_q |-> (tc_q && tog_arm_q));

endmodule

// File: rtl/evt_timer.sv
module evt_timer #(
  parameter int WIDTH       = 8,
  parameter int PRESCALE    = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tstrobe,
  input  logic             flag_a,
  input  logic             flag_b,
  input  logic             cmd_valid,
  input  logic [3:0]       cmd_code,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] count,
  output logic             get_valid,
  output logic [WIDTH-1:0] get_data,
  output logic             tc_flag,
  output logic             irq,
  output logic             out_toggle
);
  localparam int NFLAG = 2;

  logic [NFLAG-1:0] flag_raw, flag_lvl, flag_rise, flag_fall;
  logic presc_adv, presc_clr, presc_wrap;

  assign flag_raw = {flag_b, flag_a};

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    evt_timer_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (flag_raw[i]),
      .level    (flag_lvl[i]),
      .rise     (flag_rise[i]),
      .fall     (flag_fall[i])
    );
  end

  evt_timer_prescaler #(.DIV(PRESCALE)) u_presc (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (presc_clr),
    .adv   (presc_adv),
    .wrap  (presc_wrap)
  );

  evt_timer_core #(.WIDTH(WIDTH)) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .tstrobe    (tstrobe),
    .flag_lvl   (flag_lvl),
    .flag_rise  (flag_rise),
    .flag_fall  (flag_fall),
    .presc_wrap (presc_wrap),
    .presc_adv  (presc_adv),
    .presc_clr  (presc_clr),
    .cmd_valid  (cmd_valid),
    .cmd_code   (cmd_code),
    .d_in       (d_in),
    .count      (count),
    .get_valid  (get_valid),
    .get_data   (get_data),
    .tc_flag    (tc_flag),
    .irq        (irq),
    .out_toggle (out_toggle)
  );

endmodule

// File: tb/evt_timer_tb.sv
module evt_timer_tb_top;
  localparam int C_LOAD = 1, C_GET = 2, C_STOP = 3, C_STEP = 4, C_TIMER = 5;
  localparam int C_EVA = 6, C_EVB = 7, C_GTA = 8, C_GTB = 9, C_ARM = 10;
  localparam int C_ION = 11, C_IOFF = 12;
  localparam int M_IDLE = 0, M_TIM = 1, M_EVA = 2, M_EVB = 3, M_GTA = 4, M_GTB = 5;

  logic clk = 0, rst_n = 0, tstrobe = 0, flag_a = 0, flag_b = 0, cmd_valid = 0;
  logic [3:0] cmd_code = 0;
  logic [7:0] d_in = 0;
  logic [7:0] count, get_data;
  logic get_valid, tc_flag, irq, out_toggle;

  int compared = 0, mismatched = 0, cycles = 0;
  bit done = 0;
  string phase = "R10";

  always #10 clk = ~clk;

  evt_timer dut_i (.clk(clk), .rst_n(rst_n), .tstrobe(tstrobe), .flag_a(flag_a),
    .flag_b(flag_b), .cmd_valid(cmd_valid), .cmd_code(cmd_code), .d_in(d_in),
    .count(count), .get_valid(get_valid), .get_data(get_data), .tc_flag(tc_flag),
    .irq(irq), .out_toggle(out_toggle));

  // behavioural reference model
  int m_cnt, m_hold, m_mode, m_pre, m_gd;
  bit m_tc, m_ien, m_arm, m_tog, m_gv;
  bit ha[$], hb[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_hold = 0; m_mode = M_IDLE; m_pre = 0; m_gd = 0;
      m_tc = 0; m_ien = 0; m_arm = 0; m_tog = 0; m_gv = 0;
      ha = '{0, 0, 0}; hb = '{0, 0, 0};
    end else begin
      bit ra, rb, fa, fb, tick, stepit;
      int nmode, code;
      ra = ha[$-1] && !ha[$-2]; fa = !ha[$-1] && ha[$-2];
      rb = hb[$-1] && !hb[$-2]; fb = !hb[$-1] && hb[$-2];
      code = cmd_valid ? int'(cmd_code) : 0;
      tick = 0; nmode = m_mode; m_tog = 0; m_gv = 0;
      case (m_mode)
        M_TIM: if (tstrobe) begin
          if (m_pre == 31) begin tick = 1; m_pre = 0; end else m_pre++;
        end
        M_EVA: tick = ra;
        M_EVB: tick = rb;
        M_GTA: begin tick = tstrobe && ha[$-1]; if (fa) nmode = M_IDLE; end
        M_GTB: begin tick = tstrobe && hb[$-1]; if (fb) nmode = M_IDLE; end
        default: ;
      endcase
      if (code == C_LOAD || code == C_STOP || code == C_STEP) tick = 0;
      stepit = tick || (code == C_STEP);
      case (code)
        C_LOAD: begin
          m_hold = d_in;
          if (m_mode == M_IDLE) begin m_cnt = d_in; m_tc = 0; stepit = 0; end
        end
        C_GET:  begin m_gv = 1; m_gd = m_cnt; end
        C_STOP: begin nmode = M_IDLE; m_pre = 0; end
        C_TIMER: nmode = M_TIM;
        C_EVA:  nmode = M_EVA;
        C_EVB:  nmode = M_EVB;
        C_GTA:  nmode = M_GTA;
        C_GTB:  nmode = M_GTB;
        C_ARM:  m_arm = 1;
        C_ION:  m_ien = 1;
        C_IOFF: m_ien = 0;
        default: ;
      endcase
      if (stepit) begin
        if (m_cnt == 1) begin m_cnt = m_hold; m_tc = 1; m_tog = m_arm; end
        else m_cnt = (m_cnt + 255) % 256;
      end
      m_mode = nmode;
      ha.push_back(flag_a); hb.push_back(flag_b);
      if (ha.size() > 4) void'(ha.pop_front());
      if (hb.size() > 4) void'(hb.pop_front());
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      compared++;
      if (count !== m_cnt[7:0] || tc_flag !== m_tc || irq !== (m_tc && m_ien) ||
          out_toggle !== m_tog || get_valid !== m_gv ||
          (m_gv && get_data !== m_gd[7:0])) begin
        mismatched++;
        $display("FAIL %s: act cnt=%0d tc=%0b irq=%0b tog=%0b gv=%0b gd=%0d exp cnt=%0d tc=%0b irq=%0b tog=%0b gv=%0b gd=%0d",
          phase, count, tc_flag, irq, out_toggle, get_valid, get_data,
          m_cnt, m_tc, m_tc && m_ien, m_tog, m_gv, m_gd);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      mismatched++;
      $display("FAIL watchdog: act cycles=%0d exp below 100000", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic issue(input int code, input int val);
    cmd_valid = 1; cmd_code = code[3:0]; d_in = val[7:0];
    @(negedge clk);
    cmd_valid = 0; cmd_code = 0; d_in = 0;
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      tstrobe = 1; @(negedge clk);
      tstrobe = 0; @(negedge clk);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    phase = "R10";
    chk("R10 reset count", count, 0);
    chk("R10 reset irq", irq, 0);
    chk("R10 reset tc", tc_flag, 0);

    phase = "R1";
    issue(C_LOAD, 5);
    chk("R1 load stopped", count, 5);
    phase = "R12";
    issue(13, 9); issue(0, 9); issue(15, 9);
    chk("R12 unused code", count, 5);
    phase = "R11";
    for (int i = 0; i < 4; i++) issue(C_STEP, 0);
    chk("R11 manual step", count, 1);
    phase = "R4";
    issue(C_STEP, 0);
    chk("R4 reload keeps old hold", count, 5);
    chk("R4 tc set", tc_flag, 1);
    phase = "R10";
    issue(C_ION, 0);
    chk("R10 irq on", irq, 1);
    issue(C_IOFF, 0);
    chk("R10 irq masked", irq, 0);
    issue(C_ION, 0);
    phase = "R1";
    issue(C_LOAD, 0);
    chk("R1 load clears tc", tc_flag, 0);
    phase = "R4";
    issue(C_STEP, 0);
    chk("R4 wrap", count, 255);
    chk("R4 wrap no tc", tc_flag, 0);

    phase = "R5";
    issue(C_LOAD, 2); issue(C_ARM, 0); issue(C_TIMER, 0);
    pulses(31);
    chk("R5 31 strobes", count, 2);
    pulses(1);
    chk("R5 32 strobes", count, 1);
    pulses(31);
    phase = "R8";
    tstrobe = 1; @(negedge clk);
    chk("R8 toggle pulse", out_toggle, 1);
    chk("R4 timer reload", count, 2);
    tstrobe = 0; @(negedge clk);
    chk("R8 toggle one cycle", out_toggle, 0);

    phase = "R2";
    issue(C_LOAD, 7);
    chk("R2 count kept", count, 2);
    pulses(64);
    chk("R2 new reload", count, 7);

    phase = "R3";
    pulses(10);
    issue(C_STOP, 0); issue(C_TIMER, 0);
    pulses(31);
    chk("R3 prescaler cleared", count, 7);
    pulses(1);
    chk("R3 first step after restart", count, 6);
    issue(C_STOP, 0);
    pulses(40);
    chk("R3 stopped ignores strobes", count, 6);

    phase = "R11";
    issue(C_TIMER, 0);
    pulses(31);
    tstrobe = 1; issue(C_STEP, 0); tstrobe = 0; @(negedge clk);
    chk("R11 collision single step", count, 5);
    pulses(31);
    chk("R11 no extra step", count, 5);
    pulses(1);
    chk("R11 next period", count, 4);
    issue(C_STOP, 0);

    phase = "R9";
    issue(C_GET, 0);
    chk("R9 get valid", get_valid, 1);
    chk("R9 get data", get_data, 4);
    @(negedge clk);
    chk("R9 valid one cycle", get_valid, 0);

    phase = "R6";
    issue(C_LOAD, 3); issue(C_EVA, 0);
    flag_a = 1;
    @(negedge clk); chk("R6 edge1", count, 3);
    @(negedge clk); chk("R6 edge2", count, 3);
    @(negedge clk); chk("R6 edge3", count, 2);
    idle(3); flag_a = 0; idle(5);
    chk("R6 fall no step", count, 2);
    flag_b = 1; idle(5); flag_b = 0; idle(5);
    chk("R6 other line ignored", count, 2);
    flag_a = 1; idle(5); flag_a = 0; idle(5);
    chk("R6 second edge", count, 1);
    flag_a = 1; idle(5); flag_a = 0; idle(5);
    chk("R6 reload", count, 3);
    issue(C_EVB, 0);
    flag_b = 1; idle(5); flag_b = 0; idle(5);
    flag_a = 1; idle(5); flag_a = 0; idle(5);
    chk("R6 line B", count, 2);

    phase = "R7";
    issue(C_GTA, 0);
    pulses(2);
    chk("R7 gate low no step", count, 2);
    flag_a = 1; idle(4);
    pulses(3);
    chk("R7 gated steps", count, 2);
    flag_a = 0; idle(4);
    pulses(3);
    chk("R7 stopped after fall", count, 2);
    issue(C_LOAD, 9);
    chk("R7 load sees stopped", count, 9);
    issue(C_GTB, 0);
    flag_b = 1; idle(4);
    pulses(2);
    chk("R7 gate B steps", count, 7);
    flag_b = 0; idle(4);
    pulses(2);
    chk("R7 gate B ended", count, 7);

    idle(3);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule